// File: doc/BRIEF.md
# NAND Flash Command and Address Decoder

This block is the device-side front end of an 8-bit NAND flash interface. It watches the shared byte bus together with chip enable, the write strobe and the two latch enables, and turns each byte written by the host into a command, an address byte or a data byte. It runs on the chip's system clock. The write strobe is sampled as an ordinary synchronous input, and a byte is taken in the clock cycle where a low-to-high transition of the strobe is seen while chip enable is low.

Command bytes drive a sequence recogniser. It handles single-byte commands and the two- and three-step sequences for program, erase and copy-back. It counts address cycles per operation: four for read, program and copy-back, where one column byte comes first and three row bytes follow, and three for erase, which has row bytes only. It keeps a read-area pointer that selects the low half, the high half or the spare columns of a page. When a sequence completes, a one-cycle request with the assembled column and row goes to a downstream array controller. Broken sequences raise a one-cycle error flag.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is taken only in the clock cycle where we_n is seen rising (low in the previous cycle, high now) while ce_n is low. With ce_n high, writes have no effect.
- R2: cle high with ale low makes the byte a command. ale high with cle low makes it an address byte. Both low makes it a data byte, which is passed out only during the program data phase. Both high causes the byte to be ignored.
- R3: 00h, 01h or 50h followed by four address bytes gives a read request (op 1) on the fourth byte. The order is column byte, then row bytes least significant first.
- R4: The column is the byte itself under 00h, 256 plus the byte under 01h, and 512 plus the low four bits of the byte under 50h, which is the range 512 to 527.
- R5: The 01h area applies to one read or program only and then returns to the 00h area. The 50h and 00h areas stay selected until changed.
- R6: 80h, four address bytes, any number of data bytes, then 10h gives a program request (op 2, flag 0), and 11h instead gives op 2 with flag 1. Each data byte appears once on dat_valid/dat_byte.
- R7: 60h followed by three row bytes, repeated for up to 4 planes and confirmed by D0h, gives an erase request (op 4) with req_planes equal to the number of 60h commands and the last row. A fifth 60h is an error.
- R8: Copy-back is 00h or 03h with four address bytes, then 8Ah with four address bytes, then 10h (flag 0) or 11h (flag 1), and it gives op 3 with the destination address. The 00h start also gives a read request. The 03h start gives none.
- R9: 90h gives an ID request (op 6). 70h and 71h give a status request (op 5) with flag 0 and flag 1 and leave any sequence in progress intact. FFh gives a reset request (op 7), aborts any sequence and restores the 00h area.
- R10: While busy is high, only FFh, 70h and 71h are acted on. Every other byte is ignored, with no request, no error and no change of sequence state.
- R11: An undefined command, a confirm or 8Ah out of sequence, a command in the middle of an address phase, or an address byte outside an address phase raises seq_err for one cycle and returns the decoder to idle.
- R12: req_col and req_row change only on accepted address bytes and on the start of a new address phase. They are held from the last address byte through the confirm.
- R13: Requests and errors are one-cycle pulses, registered one clock after the cycle that sees the strobe rise. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, byte taken on its rising transition |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io | input | 8 | Shared command/address/data byte |
| busy | input | 1 | Array operation in progress |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 3 | Operation: 1 read, 2 program, 3 copy-back, 4 erase, 5 status, 6 ID, 7 reset |
| req_flag | output | 1 | Dummy program/copy-back, or multi-plane status |
| req_col | output | 10 | Assembled column, 0 to 527 |
| req_row | output | 24 | Assembled row, first row byte in bits 7:0 |
| req_planes | output | 3 | Number of planes queued for erase |
| dat_valid | output | 1 | One-cycle data byte strobe in program data phase |
| dat_byte | output | 8 | Data byte |
| seq_err | output | 1 | One-cycle sequence error |

## Verification
A wrong sequence state shows up at the ports on the very next command or address byte. A confirm then produces seq_err where a request was due, or a stray address produces an error, so the bench follows each disturbance (busy, status, pointer use) with the byte that tells whether the state survived. A wrong address counter or area pointer shows on the request that completes the phase, as a misplaced column or row value in the same cycle as req_valid. The full command-byte sweep and column sweeps expose any encoding slip within one write.

// File: rtl/nand_dec_pkg.sv
// Shared types and command encodings for the NAND command decoder.
// Assumes an 8-bit bus; encodings are fixed by the host protocol.
package nand_dec_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_PROG  = 3'd2,
        OP_COPY  = 3'd3,
        OP_ERASE = 3'd4,
        OP_STAT  = 3'd5,
        OP_ID    = 3'd6,
        OP_RESET = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        AREA_LO = 2'd0,
        AREA_HI = 2'd1,
        AREA_SP = 2'd2
    } area_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RADDR, S_PADDR, S_PDATA, S_EADDR, S_ECONF, S_CBADDR, S_CBCONF
    } st_e;

    localparam logic [7:0] C_RD_LO    = 8'h00;
    localparam logic [7:0] C_RD_HI    = 8'h01;
    localparam logic [7:0] C_CB_SRC   = 8'h03;
    localparam logic [7:0] C_RD_SP    = 8'h50;
    localparam logic [7:0] C_PRG      = 8'h80;
    localparam logic [7:0] C_ERS      = 8'h60;
    localparam logic [7:0] C_ID       = 8'h90;
    localparam logic [7:0] C_STAT     = 8'h70;
    localparam logic [7:0] C_MSTAT    = 8'h71;
    localparam logic [7:0] C_RST      = 8'hFF;
    localparam logic [7:0] C_CB_DST   = 8'h8A;
    localparam logic [7:0] C_GO       = 8'h10;
    localparam logic [7:0] C_GO_DUMMY = 8'h11;
    localparam logic [7:0] C_ERS_GO   = 8'hD0;

endpackage

// File: rtl/nand_bus_sampler.sv
// Detects a rising write strobe under chip enable and classifies the byte.
// Assumes we_n is already synchronous to clk; one registered stage of history.
module nand_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic cle,
    input  logic ale,
    output logic cmd_stb,
    output logic adr_stb,
    output logic dat_stb
);

    logic we_q;
    logic edge_seen;

    // Remember last strobe level to find its rising transition.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // Classify the byte in the cycle of the strobe rise.
    always_comb begin
        edge_seen = !ce_n && we_n && !we_q;
        cmd_stb   = edge_seen &&  cle && !ale;
        adr_stb   = edge_seen && !cle &&  ale;
        dat_stb   = edge_seen && !cle && !ale;
    end

    // R1: a strobe rise needs a low cycle before it, so strobes never abut.
    a_r1_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb || adr_stb || dat_stb) |=> !(cmd_stb || adr_stb || dat_stb));

endmodule

// File: rtl/nand_addr_asm.sv
// Counts address bytes and assembles column and row for the active phase.
// Assumes the sequencer pulses clr at the start of each address phase and
// raises take only for accepted address bytes.
module nand_addr_asm
    import nand_dec_pkg::*;
#(
    parameter int PAGE_HALF  = 256,
    parameter int SPARE_COLS = 16,
    parameter int ROW_CYC    = 3,
    parameter int COL_W      = 10,
    parameter int ROW_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic             with_col,
    input  area_e            area,
    input  logic [7:0]       byte_in,
    output logic             last,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);

    localparam int CNT_W = $clog2(ROW_CYC + 2);
    localparam int SP_W  = $clog2(SPARE_COLS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] row_idx;
    logic [COL_W-1:0] col_next;

    // Cycle count for this phase, final-byte detect and column mapping.
    always_comb begin
        need    = with_col ? CNT_W'(ROW_CYC + 1) : CNT_W'(ROW_CYC);
        last    = take && (cnt == need - CNT_W'(1));
        row_idx = with_col ? cnt - CNT_W'(1) : cnt;
        case (area)
            AREA_HI: col_next = COL_W'(PAGE_HALF) + COL_W'(byte_in);
            AREA_SP: col_next = COL_W'(2 * PAGE_HALF) + COL_W'(byte_in[SP_W-1:0]);
            default: col_next = COL_W'(byte_in);
        endcase
    end

    // Store column byte first (if any), then row bytes low to high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            col <= '0;
            row <= '0;
        end else if (clr) begin
            cnt <= '0;
            row <= '0;
        end else if (take) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
            if (with_col && cnt == '0) begin
                col <= col_next;
            end else begin
                for (int i = 0; i < ROW_CYC; i++) begin
                    if (row_idx == CNT_W'(i)) row[8*i +: 8] <= byte_in;
                end
            end
        end
    end

    // R12: address registers hold unless a byte is taken or a phase starts.
    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(row) && $stable(col)));

endmodule

// File: rtl/nand_seq_fsm.sv
// Recognises command sequences, tracks the read-area pointer and erase
// plane count, and emits one-cycle requests, data strobes and errors.
// Assumes at most one strobe per cycle from the sampler.
module nand_seq_fsm
    import nand_dec_pkg::*;
#(
    parameter int MAX_PLANES = 4,
    parameter int PL_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_stb,
    input  logic            adr_stb,
    input  logic            dat_stb,
    input  logic [7:0]      byte_in,
    input  logic            busy,
    input  logic            addr_last,
    output logic            clr,
    output logic            take,
    output logic            with_col,
    output area_e           area,
    output logic            req_valid,
    output op_e             req_op,
    output logic            req_flag,
    output logic [PL_W-1:0] req_planes,
    output logic            dat_valid,
    output logic [7:0]      dat_byte,
    output logic            seq_err
);

    st_e             state, nxt_state;
    area_e           nxt_area;
    logic            cb_ok, nxt_cb;
    logic            rd_issue, nxt_rd;
    logic [PL_W-1:0] planes, nxt_pl;
    logic            cmd_ok, in_addr, busy_ok_cmd;
    logic            p_valid, p_flag, p_err, p_dv;
    op_e             p_op;

    // Acceptance gating and address-phase control toward the assembler.
    always_comb begin
        busy_ok_cmd = (byte_in == C_RST) || (byte_in == C_STAT) || (byte_in == C_MSTAT);
        cmd_ok      = cmd_stb && (!busy || busy_ok_cmd);
        in_addr     = (state == S_RADDR) || (state == S_PADDR) ||
                      (state == S_EADDR) || (state == S_CBADDR);
        take        = adr_stb && !busy && in_addr;
        with_col    = (state != S_EADDR);
    end

    // Next-state, pointer, plane count and pulse decode.
    always_comb begin
        nxt_state = state;
        nxt_area  = area;
        nxt_cb    = cb_ok;
        nxt_rd    = rd_issue;
        nxt_pl    = planes;
        p_valid   = 1'b0;
        p_op      = OP_NONE;
        p_flag    = 1'b0;
        p_err     = 1'b0;
        p_dv      = 1'b0;
        clr       = 1'b0;
        if (cmd_ok) begin
            if (byte_in == C_RST) begin
                nxt_state = S_IDLE;
                nxt_area  = AREA_LO;
                nxt_cb    = 1'b0;
                nxt_pl    = '0;
                p_valid   = 1'b1;
                p_op      = OP_RESET;
            end else if (byte_in == C_STAT || byte_in == C_MSTAT) begin
                p_valid = 1'b1;
                p_op    = OP_STAT;
                p_flag  = (byte_in == C_MSTAT);
            end else begin
                nxt_cb = 1'b0;
                case (state)
                    S_IDLE: begin
                        case (byte_in)
                            C_RD_LO:  begin nxt_area = AREA_LO; nxt_rd = 1'b1; nxt_state = S_RADDR; clr = 1'b1; end
                            C_RD_HI:  begin nxt_area = AREA_HI; nxt_rd = 1'b1; nxt_state = S_RADDR; clr = 1'b1; end
                            C_RD_SP:  begin nxt_area = AREA_SP; nxt_rd = 1'b1; nxt_state = S_RADDR; clr = 1'b1; end
                            C_CB_SRC: begin nxt_rd = 1'b0; nxt_state = S_RADDR; clr = 1'b1; end
                            C_PRG:    begin nxt_state = S_PADDR; clr = 1'b1; end
                            C_ERS:    begin nxt_state = S_EADDR; nxt_pl = PL_W'(1); clr = 1'b1; end
                            C_ID:     begin p_valid = 1'b1; p_op = OP_ID; end
                            C_CB_DST: begin
                                if (cb_ok) begin nxt_state = S_CBADDR; clr = 1'b1; end
                                else p_err = 1'b1;
                            end
                            default:  p_err = 1'b1;
                        endcase
                    end
                    S_PDATA: begin
                        if (byte_in == C_GO || byte_in == C_GO_DUMMY) begin
                            p_valid   = 1'b1;
                            p_op      = OP_PROG;
                            p_flag    = (byte_in == C_GO_DUMMY);
                            nxt_state = S_IDLE;
                            if (area == AREA_HI) nxt_area = AREA_LO;
                        end else p_err = 1'b1;
                    end
                    S_ECONF: begin
                        if (byte_in == C_ERS && planes < PL_W'(MAX_PLANES)) begin
                            nxt_pl    = planes + PL_W'(1);
                            nxt_state = S_EADDR;
                            clr       = 1'b1;
                        end else if (byte_in == C_ERS_GO) begin
                            p_valid   = 1'b1;
                            p_op      = OP_ERASE;
                            nxt_state = S_IDLE;
                        end else p_err = 1'b1;
                    end
                    S_CBCONF: begin
                        if (byte_in == C_GO || byte_in == C_GO_DUMMY) begin
                            p_valid   = 1'b1;
                            p_op      = OP_COPY;
                            p_flag    = (byte_in == C_GO_DUMMY);
                            nxt_state = S_IDLE;
                        end else p_err = 1'b1;
                    end
                    default: p_err = 1'b1;
                endcase
                if (p_err) nxt_state = S_IDLE;
            end
        end else if (take) begin
            if (addr_last) begin
                case (state)
                    S_RADDR: begin
                        nxt_state = S_IDLE;
                        nxt_cb    = 1'b1;
                        if (rd_issue) begin
                            p_valid = 1'b1;
                            p_op    = OP_READ;
                            if (area == AREA_HI) nxt_area = AREA_LO;
                        end
                    end
                    S_PADDR:  nxt_state = S_PDATA;
                    S_EADDR:  nxt_state = S_ECONF;
                    S_CBADDR: nxt_state = S_CBCONF;
                    default:  nxt_state = state;
                endcase
            end
        end else if (adr_stb && !busy) begin
            p_err     = 1'b1;
            nxt_state = S_IDLE;
            nxt_cb    = 1'b0;
        end else if (dat_stb && !busy && state == S_PDATA) begin
            p_dv = 1'b1;
        end
    end

    // Register sequence state and the one-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            area      <= AREA_LO;
            cb_ok     <= 1'b0;
            rd_issue  <= 1'b0;
            planes    <= '0;
            req_valid <= 1'b0;
            req_op    <= OP_NONE;
            req_flag  <= 1'b0;
            seq_err   <= 1'b0;
            dat_valid <= 1'b0;
            dat_byte  <= '0;
        end else begin
            state     <= nxt_state;
            area      <= nxt_area;
            cb_ok     <= nxt_cb;
            rd_issue  <= nxt_rd;
            planes    <= nxt_pl;
            req_valid <= p_valid;
            req_op    <= p_op;
            req_flag  <= p_flag;
            seq_err   <= p_err;
            dat_valid <= p_dv;
            if (p_dv) dat_byte <= byte_in;
        end
    end

    assign req_planes = planes;

    // R13: a request never lasts two cycles.
    a_r13_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R11: an error and a request never coincide.
    a_r11_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> !req_valid);

    // R10: a command refused while busy yields neither request nor error.
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_stb && !busy_ok_cmd) |=> (!req_valid && !seq_err));

    // R7: plane count stays within the limit.
    a_r7_planes_range: assert property (@(posedge clk) disable iff (!rst_n)
        planes <= PL_W'(MAX_PLANES));

    // R7: an erase request always carries at least one plane.
    a_r7_erase_planes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_ERASE) |-> (planes != '0));

    // R6: data strobes only appear while in the program data phase.
    a_r6_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> (state == S_PDATA));

endmodule

// File: rtl/nand_cmd_decoder.sv
// Top of the NAND command/address decoder: bus sampler, address assembler
// and sequence recogniser. Assumes synchronous bus inputs, reset active low.
module nand_cmd_decoder
    import nand_dec_pkg::*;
#(
    parameter int PAGE_HALF  = 256,
    parameter int SPARE_COLS = 16,
    parameter int ROW_CYC    = 3,
    parameter int MAX_PLANES = 4,
    localparam int COL_W     = $clog2(2 * PAGE_HALF + SPARE_COLS),
    localparam int ROW_W     = 8 * ROW_CYC,
    localparam int PL_W      = $clog2(MAX_PLANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             cle,
    input  logic             ale,
    input  logic [7:0]       io,
    input  logic             busy,
    output logic             req_valid,
    output logic [2:0]       req_op,
    output logic             req_flag,
    output logic [COL_W-1:0] req_col,
    output logic [ROW_W-1:0] req_row,
    output logic [PL_W-1:0]  req_planes,
    output logic             dat_valid,
    output logic [7:0]       dat_byte,
    output logic             seq_err
);

    logic  cmd_stb, adr_stb, dat_stb;
    logic  clr, take, with_col, addr_last;
    area_e area;
    op_e   op_q;

    nand_bus_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .cle     (cle),
        .ale     (ale),
        .cmd_stb (cmd_stb),
        .adr_stb (adr_stb),
        .dat_stb (dat_stb)
    );

    nand_addr_asm #(
        .PAGE_HALF  (PAGE_HALF),
        .SPARE_COLS (SPARE_COLS),
        .ROW_CYC    (ROW_CYC),
        .COL_W      (COL_W),
        .ROW_W      (ROW_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .take     (take),
        .with_col (with_col),
        .area     (area),
        .byte_in  (io),
        .last     (addr_last),
        .col      (req_col),
        .row      (req_row)
    );

    nand_seq_fsm #(
        .MAX_PLANES (MAX_PLANES),
        .PL_W       (PL_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .adr_stb    (adr_stb),
        .dat_stb    (dat_stb),
        .byte_in    (io),
        .busy       (busy),
        .addr_last  (addr_last),
        .clr        (clr),
        .take       (take),
        .with_col   (with_col),
        .area       (area),
        .req_valid  (req_valid),
        .req_op     (op_q),
        .req_flag   (req_flag),
        .req_planes (req_planes),
        .dat_valid  (dat_valid),
        .dat_byte   (dat_byte),
        .seq_err    (seq_err)
    );

    assign req_op = op_q;

endmodule

// File: tb/nand_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nand_cmd_decoder_tb;

    logic        clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1;
    logic        cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0]  io = 8'h00;
    logic        req_valid, req_flag, dat_valid, seq_err;
    logic [2:0]  req_op, req_planes;
    logic [9:0]  req_col;
    logic [23:0] req_row;
    logic [7:0]  dat_byte;

    int checks = 0, errors = 0;
    bit done = 0;

    logic        g_v, g_fl, g_err, g_dv;
    logic [2:0]  g_op, g_pl;
    logic [9:0]  g_col;
    logic [23:0] g_row;
    logic [7:0]  g_db;

    localparam logic [2:0] RD = 3'd1, PG = 3'd2, CP = 3'd3, ER = 3'd4,
                           ST = 3'd5, ID = 3'd6, RS = 3'd7;

    always #2 clk = ~clk;

    nand_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io(io), .busy(busy), .req_valid(req_valid), .req_op(req_op),
        .req_flag(req_flag), .req_col(req_col), .req_row(req_row),
        .req_planes(req_planes), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .seq_err(seq_err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write; returns at the negedge where the registered result shows.
    task automatic wr(input bit c, input bit a, input logic [7:0] b);
        cle = c; ale = a; io = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        g_v = req_valid; g_op = req_op; g_fl = req_flag; g_err = seq_err;
        g_col = req_col; g_row = req_row; g_pl = req_planes;
        g_dv = dat_valid; g_db = dat_byte;
    endtask

    task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b); wr(1'b0, 1'b0, b); endtask

    task automatic addr4(input logic [7:0] c, input logic [23:0] r);
        adr(c); adr(r[7:0]); adr(r[15:8]); adr(r[23:16]);
    endtask

    task automatic rows3(input logic [23:0] r);
        adr(r[7:0]); adr(r[15:8]); adr(r[23:16]);
    endtask

    task automatic exp_req(input string tag, input logic [2:0] op, input bit fl);
        check(g_v && !g_err && g_op == op && g_fl == fl, tag,
              {g_v, g_err, g_op, g_fl}, {1'b1, 1'b0, op, fl});
    endtask

    task automatic exp_quiet(input string tag);
        check(!g_v && !g_err, tag, {g_v, g_err}, 0);
    endtask

    task automatic exp_err(input string tag);
        check(g_err && !g_v, tag, {g_v, g_err}, 1);
    endtask

    task automatic exp_addr(input string tag, input logic [9:0] c, input logic [23:0] r);
        check(g_col == c && g_row == r, tag, {g_col, g_row}, {c, r});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        check(!req_valid && !seq_err && !dat_valid && req_col == 0 && req_row == 0 && req_planes == 0,
              "R13 reset state", {req_valid, seq_err, dat_valid, req_col, req_row}, 0);

        // R9 R11 R3 R6 R7 R8: every command byte from idle, then FFh back to idle.
        for (int b = 0; b < 256; b++) begin
            cmd(8'(b));
            case (8'(b))
                8'h00, 8'h01, 8'h03, 8'h50, 8'h80, 8'h60: exp_quiet("R3 start command quiet");
                8'h90: exp_req("R9 ID", ID, 1'b0);
                8'h70: exp_req("R9 status", ST, 1'b0);
                8'h71: exp_req("R9 multi status", ST, 1'b1);
                8'hFF: exp_req("R9 reset", RS, 1'b0);
                default: exp_err("R11 undefined or out-of-sequence command");
            endcase
            cmd(8'hFF);
            exp_req("R9 reset aborts", RS, 1'b0);
        end

        // R3 R4: column sweep for each read area.
        for (int a = 0; a < 3; a++) begin
            for (int c = 0; c < 256; c++) begin
                logic [9:0] ec;
                r = {8'(a), 8'(c ^ 8'h5a), 8'(c)};
                cmd(a == 0 ? 8'h00 : (a == 1 ? 8'h01 : 8'h50));
                addr4(8'(c), r);
                ec = (a == 0) ? 10'(c) : (a == 1 ? 10'(256 + c) : 10'(512 + (c % 16)));
                exp_req("R3 read request", RD, 1'b0);
                exp_addr("R4 read column/row", ec, r);
            end
        end

        // R5: the high-half pointer applies once, then low half.
        cmd(8'h01); addr4(8'h40, 24'h010203);
        exp_addr("R5 high half read", 10'd320, 24'h010203);
        cmd(8'h80); addr4(8'h40, 24'h000111);
        exp_addr("R5 pointer reverted", 10'h040, 24'h000111);
        cmd(8'h10); exp_req("R6 program", PG, 1'b0);
        // R5: spare pointer persists across reads and programs.
        cmd(8'h50); addr4(8'h47, 24'h0);
        exp_addr("R4 spare read", 10'd519, 24'h0);
        cmd(8'h80); addr4(8'h47, 24'h0);
        exp_addr("R5 spare sticky program", 10'd519, 24'h0);
        cmd(8'h11); exp_req("R6 dummy program", PG, 1'b1);
        cmd(8'h80); addr4(8'h47, 24'h0);
        exp_addr("R5 spare still sticky", 10'd519, 24'h0);
        cmd(8'hFF);
        cmd(8'h80); addr4(8'h47, 24'h0);
        exp_addr("R9 reset restores low area", 10'h047, 24'h0);
        cmd(8'hFF);

        // R6 R12 R2: program with data bytes, address held through data.
        cmd(8'h80); addr4(8'h12, 24'hABCDEF);
        exp_quiet("R6 address phase quiet");
        for (int d = 0; d < 6; d++) begin
            dat(8'(d * 37 + 5));
            check(g_dv && g_db == 8'(d * 37 + 5), "R6 data byte strobe", {g_dv, g_db}, {1'b1, 8'(d * 37 + 5)});
            exp_addr("R12 address held during data", 10'h012, 24'hABCDEF);
        end
        cmd(8'h70); exp_req("R9 status mid-program", ST, 1'b0);
        cmd(8'h10); exp_req("R9 status kept sequence", PG, 1'b0);
        exp_addr("R12 address at confirm", 10'h012, 24'hABCDEF);
        dat(8'h99);
        check(!g_dv && !g_err && !g_v, "R2 data outside program ignored", {g_dv, g_err, g_v}, 0);
        wr(1'b1, 1'b1, 8'h90);
        exp_quiet("R2 both latches high ignored");
        cmd(8'h8A); exp_err("R11 8Ah after program");

        // R7: single and multi-plane erase, and plane overflow.
        cmd(8'h60); rows3(24'h123456);
        exp_addr("R12 erase row assembled", 10'h012, 24'h123456);
        cmd(8'hD0); exp_req("R7 erase", ER, 1'b0);
        check(g_pl == 3'd1 && g_row == 24'h123456, "R7 one plane", {g_pl, g_row}, {3'd1, 24'h123456});
        for (int p = 0; p < 4; p++) begin
            cmd(8'h60); exp_quiet("R7 plane command quiet");
            rows3(24'(p * 24'h010101 + 24'h000040));
        end
        cmd(8'hD0); exp_req("R7 multi-plane erase", ER, 1'b0);
        check(g_pl == 3'd4 && g_row == 24'h030343, "R7 four planes", {g_pl, g_row}, {3'd4, 24'h030343});
        for (int p = 0; p < 4; p++) begin cmd(8'h60); rows3(24'h0); end
        cmd(8'h60); exp_err("R7 fifth plane error");
        cmd(8'hD0); exp_err("R11 confirm after abort");
        cmd(8'h60); rows3(24'h1);
        cmd(8'h10); exp_err("R11 wrong confirm for erase");

        // R8: copy-back, true and dummy forms.
        cmd(8'h00); addr4(8'h05, 24'h000777);
        exp_req("R8 copy source read", RD, 1'b0);
        cmd(8'h8A); exp_quiet("R8 destination command");
        addr4(8'h06, 24'h000888); exp_quiet("R8 destination address");
        cmd(8'h10); exp_req("R8 copy-back", CP, 1'b0);
        exp_addr("R8 destination address", 10'h006, 24'h000888);
        cmd(8'h03); addr4(8'h07, 24'h000999);
        exp_quiet("R8 03h source no read");
        cmd(8'h8A); addr4(8'h08, 24'h000AAA);
        cmd(8'h11); exp_req("R8 dummy copy-back", CP, 1'b1);

        // R10: busy gating, state preserved across ignored bytes.
        busy = 1'b1;
        cmd(8'h80); exp_quiet("R10 program refused while busy");
        cmd(8'h70); exp_req("R10 status while busy", ST, 1'b0);
        busy = 1'b0;
        adr(8'h12); exp_err("R10 refused command left decoder idle");
        cmd(8'h80); addr4(8'h21, 24'h000321);
        busy = 1'b1;
        dat(8'h33);
        check(!g_dv && !g_err, "R10 data ignored while busy", {g_dv, g_err}, 0);
        cmd(8'h10); exp_quiet("R10 confirm ignored while busy");
        cmd(8'h71); exp_req("R10 multi status while busy", ST, 1'b1);
        busy = 1'b0;
        cmd(8'h10); exp_req("R10 sequence survived busy", PG, 1'b0);
        busy = 1'b1;
        cmd(8'hFF); exp_req("R10 reset while busy", RS, 1'b0);
        busy = 1'b0;

        // R1: chip enable high blocks writes.
        ce_n = 1'b1;
        cmd(8'h90); exp_quiet("R1 ce_n high ignored");
        ce_n = 1'b0;
        cmd(8'h90); exp_req("R1 ce_n low accepted", ID, 1'b0);

        // R11: command mid-address, stray address.
        cmd(8'h00); adr(8'h01); adr(8'h02);
        cmd(8'h00); exp_err("R11 command inside address phase");
        adr(8'h03); exp_err("R11 stray address");
        @(negedge clk);
        check(!req_valid && !seq_err, "R13 pulses last one cycle", {req_valid, seq_err}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule